// File: doc/BRIEF.md
# Bouncing LED Scanner with Graded Trail

This block drives a row of LEDs with a bright spot that sweeps from one end of the row to the other and back again. Two dimmer LEDs follow the spot along the path it has just taken. The spot is at full brightness, the LED it left one step ago is at half brightness, and the LED it left two steps ago is at one fifth brightness. Brightness is made by pulse-width modulation. One free-running counter with a period of 100 clock cycles serves every LED. An LED is on while that counter is below the LED's duty value.

A clock divider sets the scan speed. It makes a one-cycle step enable every `TICK_DIV` clocks; the default is 0.1 s at a 50 MHz clock. The only inputs are the clock and an active-low push-button reset. The output is one drive bit per LED, where 1 means lit, and it can go straight to the LED pins.

Top module: `trailScanner`

## Requirements
- R1: While `rstN` is low, the divider and the PWM counter hold at zero, the leader is at LED 0 and no trailing LED is lit, so `ledOut` shows only bit 0. After release the leader starts moving upward from LED 0.
- R2: The leader moves exactly one position per scan step. A step takes effect every `TICK_DIV` clock cycles, counted from the release of reset.
- R3: At either end of the row the leader reverses direction. The end LED leads for exactly one step, with no skip and no repeat.
- R4: The two trailing LEDs are the leader's previous two positions along its actual path. Right after a reversal, a trailing LED can share a position with the leader. In that case fewer than three distinct LEDs are lit. After reset the trail is empty, and it fills over the first two steps.
- R5: The LED at the leader position is lit on every cycle (duty 100 of 100).
- R6: The LED one step behind the leader is lit while the PWM count is 0 to 49 (duty 50 of 100).
- R7: The LED two steps behind the leader is lit while the PWM count is 0 to 19 (duty 20 of 100).
- R8: Every LED that is not the leader or a trailing LED is off, so no more than three bits of `ledOut` are ever high. When positions coincide, the brightest applicable duty wins.
- R9: The PWM counter runs freely with a period of 100 cycles and is not reset by scan steps. Its phase starts at 0 on the first cycle after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset from the push button, active low |
| ledOut | output | NUM_LEDS | LED drive bits, 1 = lit, bit i drives LED i |

## Verification
The hardest situation to reach is the step just after a reversal, where the oldest trailing LED lands on the leader and the overlap must resolve to full brightness. The bench uses a short five-LED row and a step period of 200 clocks, which is two whole PWM periods. This lets it walk the leader through both end reversals within eleven step windows. In every window it counts the lit cycles of each LED and compares them against 200, 100 or 40. This shows the overlapping positions at 200 and every other LED at zero. A reset applied in mid-sweep then confirms that the scan and the PWM phase both restart from the beginning.

// File: rtl/trailScannerPkg.sv
package trailScannerPkg;

  // Strobes from the control half to the datapath half, valid for one cycle
  typedef struct packed {
    logic scanStep;  // advance the leader this cycle
    logic litHead;   // PWM phase is inside the leader duty window
    logic litMid;    // PWM phase is inside the first trailing duty window
    logic litTail;   // PWM phase is inside the second trailing duty window
  } scanStrobes_t;

endpackage

// File: rtl/trailScanCtrl.sv
module trailScanCtrl
  import trailScannerPkg::*;
#(
  parameter int TICK_DIV   = 5_000_000,
  parameter int PWM_PERIOD = 100,
  parameter int DUTY_HEAD  = 100,
  parameter int DUTY_MID   = 50,
  parameter int DUTY_TAIL  = 20
) (
  input  logic         clk,
  input  logic         rstN,
  output scanStrobes_t strobes
);
  localparam int TICK_W = $clog2(TICK_DIV + 1);
  localparam int PWM_W  = $clog2(PWM_PERIOD + 1);

  logic [TICK_W-1:0] tickCnt;
  logic [PWM_W-1:0]  pwmCnt;
  logic              tickLast;
  logic              pwmLast;

  assign tickLast = (tickCnt == TICK_W'(TICK_DIV - 1));
  assign pwmLast  = (pwmCnt == PWM_W'(PWM_PERIOD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickLast) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCnt <= '0;
    end else if (pwmLast) begin
      pwmCnt <= '0;
    end else begin
      pwmCnt <= pwmCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.scanStep = tickLast;
    strobes.litHead  = ({1'b0, pwmCnt} < (PWM_W + 1)'(DUTY_HEAD));
    strobes.litMid   = ({1'b0, pwmCnt} < (PWM_W + 1)'(DUTY_MID));
    strobes.litTail  = ({1'b0, pwmCnt} < (PWM_W + 1)'(DUTY_TAIL));
  end

endmodule

// File: rtl/trailScanPath.sv
module trailScanPath
  import trailScannerPkg::*;
#(
  parameter int NUM_LEDS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  scanStrobes_t        strobes,
  output logic [NUM_LEDS-1:0] ledOut
);
  localparam int POS_W = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1;
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(NUM_LEDS - 1);

  logic [POS_W-1:0] headPos, midPos, tailPos;
  logic             midOn, tailOn;
  logic             goingUp;
  logic [POS_W-1:0] nextHead;
  logic             nextUp;

  always_comb begin
    nextHead = headPos;
    nextUp   = goingUp;
    if (goingUp) begin
      if (headPos == TOP_POS) begin
        nextHead = headPos - 1'b1;
        nextUp   = 1'b0;
      end else begin
        nextHead = headPos + 1'b1;
      end
    end else begin
      if (headPos == '0) begin
        nextHead = headPos + 1'b1;
        nextUp   = 1'b1;
      end else begin
        nextHead = headPos - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPos <= '0;
      midPos  <= '0;
      tailPos <= '0;
      midOn   <= 1'b0;
      tailOn  <= 1'b0;
      goingUp <= 1'b1;
    end else if (strobes.scanStep) begin
      tailPos <= midPos;
      tailOn  <= midOn;
      midPos  <= headPos;
      midOn   <= 1'b1;
      headPos <= nextHead;
      goingUp <= nextUp;
    end
  end

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    logic atHead, atMid, atTail;
    assign atHead    = (headPos == POS_W'(i));
    assign atMid     = midOn  && (midPos  == POS_W'(i));
    assign atTail    = tailOn && (tailPos == POS_W'(i));
    assign ledOut[i] = (atHead && strobes.litHead) ||
                       (atMid  && strobes.litMid)  ||
                       (atTail && strobes.litTail);
  end

endmodule

// File: rtl/trailScanner.sv
module trailScanner
  import trailScannerPkg::*;
#(
  parameter int NUM_LEDS   = 8,
  parameter int TICK_DIV   = 5_000_000,
  parameter int PWM_PERIOD = 100,
  parameter int DUTY_HEAD  = 100,
  parameter int DUTY_MID   = 50,
  parameter int DUTY_TAIL  = 20
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [NUM_LEDS-1:0] ledOut
);
  scanStrobes_t strobes;

  trailScanCtrl #(
    .TICK_DIV  (TICK_DIV),
    .PWM_PERIOD(PWM_PERIOD),
    .DUTY_HEAD (DUTY_HEAD),
    .DUTY_MID  (DUTY_MID),
    .DUTY_TAIL (DUTY_TAIL)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes)
  );

  trailScanPath #(
    .NUM_LEDS(NUM_LEDS)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .ledOut (ledOut)
  );

endmodule

// File: rtl/trailScannerChk.sv
module trailScannerChk
  import trailScannerPkg::*;
#(
  parameter int NUM_LEDS = 8,
  parameter int TICK_DIV = 5_000_000
) (
  input logic                clk,
  input logic                rstN,
  input scanStrobes_t        strobes,
  input logic [NUM_LEDS-1:0] ledOut
);

  // R8
  max_three_lit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ledOut) <= 3);

  // R5
  head_always_lit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.litHead |-> (ledOut != '0));

  // R6
  only_head_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.litMid |-> ($countones(ledOut) == 1));

  // R2
  single_cycle_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (TICK_DIV > 1 && strobes.scanStep) |=> !strobes.scanStep);

  // R7
  tail_window_nested_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.litMid) |-> !strobes.litTail);

endmodule

bind trailScanner trailScannerChk #(
  .NUM_LEDS(NUM_LEDS),
  .TICK_DIV(TICK_DIV)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .strobes(strobes),
  .ledOut (ledOut)
);

// File: tb/trailScanner_bench.sv
module trailScanner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEDS       = 5;
  localparam int DIV        = 200;
  localparam int WINDOWS    = 11;
  localparam logic [2:0] NONE = 3'd7;

  // {leader, first trailing, second trailing}; 7 = not lit
  localparam logic [8:0] PATH [WINDOWS] = '{
    {3'd0, NONE, NONE},  // R1 empty trail after reset
    {3'd1, 3'd0, NONE},  // R4 trail filling
    {3'd2, 3'd1, 3'd0},
    {3'd3, 3'd2, 3'd1},
    {3'd4, 3'd3, 3'd2},  // R3 top end
    {3'd3, 3'd4, 3'd3},  // R4 overlap after reversal
    {3'd2, 3'd3, 3'd4},
    {3'd1, 3'd2, 3'd3},
    {3'd0, 3'd1, 3'd2},  // R3 bottom end
    {3'd1, 3'd0, 3'd1},  // R4 overlap after reversal
    {3'd2, 3'd1, 3'd0}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [LEDS-1:0] ledOut;
  int              testCount = 0;
  int              failCount = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trailScanner #(
    .NUM_LEDS(LEDS),
    .TICK_DIV(DIV)
  ) u_trailScanner (
    .clk   (clk),
    .rstN  (rstN),
    .ledOut(ledOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int expectOn(input logic [8:0] entry, input int led);
    int best = 0;
    if (entry[2:0] == 3'(led)) best = 2 * 20;
    if (entry[5:3] == 3'(led)) best = 2 * 50;
    if (entry[8:6] == 3'(led)) best = 2 * 100;
    return best;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    testCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [LEDS-1:0] snap10, snap30, snap60, lastOfWin0;
    // R1 reset holds state
    repeat (3) @(negedge clk);
    check("R1 reset shows only LED 0", int'(ledOut), 1);
    repeat (7) @(negedge clk);
    check("R1 reset state held", int'(ledOut), 1);

    rstN = 1'b1;
    // table walk: sample n = 0 is the release negedge
    for (int w = 0; w < WINDOWS; w++) begin
      int onCnt [LEDS];
      for (int i = 0; i < LEDS; i++) onCnt[i] = 0;
      for (int c = 0; c < DIV; c++) begin
        #1;
        for (int i = 0; i < LEDS; i++) if (ledOut[i]) onCnt[i]++;
        if (w == 2 && c == 10) snap10 = ledOut;
        if (w == 2 && c == 30) snap30 = ledOut;
        if (w == 2 && c == 60) snap60 = ledOut;
        @(negedge clk);
      end
      for (int i = 0; i < LEDS; i++)
        check($sformatf("R2 R3 R4 R5 R6 R7 R8 window %0d led %0d", w, i),
              onCnt[i], expectOn(PATH[w], i));
    end

    // R9 phase checks inside window 2 (leader 2, trail 1 then 0)
    check("R7 PWM count 10 all three lit", int'(snap10), 5'b00111);
    check("R6 PWM count 30 leader and first trail", int'(snap30), 5'b00110);
    check("R9 PWM count 60 leader alone", int'(snap60), 5'b00100);

    // R1 reset in mid-sweep
    rstN = 1'b0;
    #1;
    check("R1 async reset clears sweep", int'(ledOut), 1);
    repeat (4) @(negedge clk);
    check("R1 reset held mid-run", int'(ledOut), 1);
    rstN = 1'b1;
    for (int c = 0; c < DIV; c++) begin
      #1;
      if (c == DIV - 1) lastOfWin0 = ledOut;
      @(negedge clk);
    end
    #1;
    check("R2 no step before divider expires", int'(lastOfWin0), 5'b00001);
    check("R2 R9 step lands with PWM phase 0", int'(ledOut), 5'b00011);
    repeat (60) @(negedge clk);
    #1;
    check("R6 first trail dark past duty 50", int'(ledOut), 5'b00010);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule